// File: doc/BRIEF.md
# Two-Gate Interrupt Mask Controller

This block collects level-sensitive interrupt sources and presents each of up to four processors with its own interrupt line and its own acknowledge value. A source must get through two gates before it can reach a processor. The first is a single enable per source that is shared by all processors. The second is a mask that each processor keeps for itself. Sources above a fixed boundary are shared, and a per-source routing bitmap also decides which processors may see them. Sources at or below the boundary are private to each processor, so routing does not apply to them.

Software never rewrites a bitmap. It writes a source number to a set register or to a clear register, which makes each change atomic with respect to the other processors. A single register port carries the access. A processor-number input says which processor is making it, and this selects that processor's copy of the banked mask and acknowledge registers. Reading the acknowledge register returns the lowest-numbered source that is pending for that processor. Because sources are level-sensitive, the read leaves the source untouched.

Address map (byte addresses): `0x000` info (read), `0x010` enable-set, `0x014` enable-clear, `0x400 + 4*n` routing word of source n, `0x800` acknowledge (banked read), `0x808` mask-set (banked), `0x80C` mask-clear (banked).

Top module: `irq_two_gate_ctrl`

## Requirements
- R1: After reset every source is globally disabled, masked on every processor and routed nowhere. As a result `irq_out` is zero and every acknowledge read returns 1023.
- R2: A read of `0x000` returns the number of implemented sources in bits [11:2], with all other bits zero.
- R3: Writing index n to `0x010` sets the global enable of source n, and writing it to `0x014` clears it. A written value whose bits [31:10] are not all zero, or whose value is at least the source count, changes nothing.
- R4: Writing index n to `0x808` masks source n for the processor on `bus_cpu`, and writing it to `0x80C` unmasks it. The masks of the other processors are left unchanged.
- R5: A write to `0x400 + 4*n` stores bits [NUM_CPU-1:0] as the routing bitmap of source n, where bit c means processor c. A read of that address returns the bitmap, and the upper bits read as zero.
- R6: A shared source (number above 28) is pending for processor c only when it is asserted, globally enabled, unmasked for c and routed to c.
- R7: A private source (number 28 or below) is pending for processor c when it is asserted, globally enabled and unmasked for c, whatever its routing bitmap holds.
- R8: A read of `0x800` returns, in bits [9:0], the lowest-numbered source pending for the reading processor, or 1023 when none is pending. Reading does not clear anything.
- R9: `irq_out[c]` is high exactly when some source is pending for processor c. It follows source levels at once and register writes from the next cycle.
- R10: Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read. Unmapped and write-only addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_in | input | NUM_SRC | Level-sensitive interrupt sources |
| bus_cpu | input | CPU_W | Number of the processor making the access |
| bus_wr | input | 1 | Write strobe, never together with bus_rd |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_out | output | NUM_CPU | Interrupt request per processor |

## Verification
Two events can land in the same cycle: a source level changing and an acknowledge read being sampled, or a mask or enable write landing on the source that currently wins arbitration. The bench drops and raises source lines at the same time as it issues reads and writes to the winning index, in both directed and random sequences. A behavioural model takes the register state and source levels at each edge and compares every cycle's interrupt lines and read data, so a read must report exactly the state present at its own edge.

// File: rtl/icm_pkg.sv
package icm_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NONE_ID = '1;

  localparam logic [11:0] A_INFO    = 12'h000;
  localparam logic [11:0] A_EN_SET  = 12'h010;
  localparam logic [11:0] A_EN_CLR  = 12'h014;
  localparam logic [11:0] A_ACK     = 12'h800;
  localparam logic [11:0] A_MSK_SET = 12'h808;
  localparam logic [11:0] A_MSK_CLR = 12'h80C;
  localparam logic [1:0]  RT_WIN    = 2'b01;
endpackage

// File: rtl/icm_gate_store.sv
module icm_gate_store #(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 64,
  localparam int IDX_W = $clog2(NUM_SRC),
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             en_set,
  input  logic                             en_clr,
  input  logic                             msk_set,
  input  logic                             msk_clr,
  input  logic [IDX_W-1:0]                 idx,
  input  logic [CPU_W-1:0]                 cpu,
  input  logic                             rt_we,
  input  logic [IDX_W-1:0]                 rt_idx,
  input  logic [NUM_CPU-1:0]               rt_val,
  output logic [NUM_SRC-1:0]               gen_en,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0]  mask_q,
  output logic [NUM_SRC-1:0][NUM_CPU-1:0]  route_q
);
  logic [NUM_SRC-1:0] en_d;
  logic               en_ce;

  always_comb begin
    en_d = gen_en;
    if (en_set) en_d[idx] = 1'b1;
    if (en_clr) en_d[idx] = 1'b0;
  end
  assign en_ce = en_set | en_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     gen_en <= '0;
    else if (en_ce) gen_en <= en_d;
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_mask
    logic [NUM_SRC-1:0] row_d;
    logic               row_ce;
    logic               mine;
    assign mine   = (cpu == CPU_W'(c));
    assign row_ce = mine & (msk_set | msk_clr);
    always_comb begin
      row_d = mask_q[c];
      if (msk_set) row_d[idx] = 1'b1;
      if (msk_clr) row_d[idx] = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask_q[c] <= '1;
      else if (row_ce) mask_q[c] <= row_d;
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_route
    logic rt_ce;
    assign rt_ce = rt_we & (rt_idx == IDX_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     route_q[s] <= '0;
      else if (rt_ce) route_q[s] <= rt_val;
    end
  end
endmodule

// File: rtl/icm_pick.sv
module icm_pick
  import icm_pkg::*;
#(
  parameter int NUM_SRC   = 64,
  parameter int PRIV_LAST = 28
) (
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [NUM_SRC-1:0] gen_en,
  input  logic [NUM_SRC-1:0] mask_row,
  input  logic [NUM_SRC-1:0] route_col,
  output logic               hit,
  output logic [ID_W-1:0]    id
);
  logic [NUM_SRC-1:0] pend;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_pend
    if (s <= PRIV_LAST) begin : g_priv
      assign pend[s] = src_in[s] & gen_en[s] & ~mask_row[s];
    end else begin : g_shared
      assign pend[s] = src_in[s] & gen_en[s] & ~mask_row[s] & route_col[s];
    end
  end

  assign hit = |pend;

  always_comb begin
    id = NONE_ID;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (pend[s]) id = s[ID_W-1:0];
    end
  end
endmodule

// File: rtl/irq_two_gate_ctrl.sv
module irq_two_gate_ctrl
  import icm_pkg::*;
#(
  parameter int NUM_CPU   = 4,
  parameter int NUM_SRC   = 64,
  parameter int PRIV_LAST = 28,
  localparam int IDX_W = $clog2(NUM_SRC),
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [CPU_W-1:0]   bus_cpu,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_CPU-1:0] irq_out
);
  logic [1:0] rst_pipe;
  logic       rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync = rst_pipe[1];

  logic                             idx_ok, cpu_ok, rt_hit;
  logic [IDX_W-1:0]                 idx, rt_idx;
  logic [NUM_SRC-1:0]               gen_en;
  logic [NUM_CPU-1:0][NUM_SRC-1:0]  mask_q;
  logic [NUM_SRC-1:0][NUM_CPU-1:0]  route_q;
  logic [NUM_CPU-1:0][ID_W-1:0]     ack_id;

  assign idx_ok = (bus_wdata[31:ID_W] == '0) && (32'(bus_wdata[ID_W-1:0]) < NUM_SRC);
  assign idx    = bus_wdata[IDX_W-1:0];
  assign cpu_ok = (32'(bus_cpu) < NUM_CPU);
  assign rt_hit = (bus_addr[11:10] == RT_WIN) && (bus_addr[1:0] == 2'b00)
                  && (32'(bus_addr[9:2]) < NUM_SRC);
  assign rt_idx = bus_addr[IDX_W+1:2];

  icm_gate_store #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync),
    .en_set  (bus_wr & idx_ok & (bus_addr == A_EN_SET)),
    .en_clr  (bus_wr & idx_ok & (bus_addr == A_EN_CLR)),
    .msk_set (bus_wr & idx_ok & cpu_ok & (bus_addr == A_MSK_SET)),
    .msk_clr (bus_wr & idx_ok & cpu_ok & (bus_addr == A_MSK_CLR)),
    .idx     (idx),
    .cpu     (bus_cpu),
    .rt_we   (bus_wr & rt_hit),
    .rt_idx  (rt_idx),
    .rt_val  (bus_wdata[NUM_CPU-1:0]),
    .gen_en  (gen_en),
    .mask_q  (mask_q),
    .route_q (route_q)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SRC-1:0] rcol;
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_col
      assign rcol[s] = route_q[s][c];
    end
    icm_pick #(.NUM_SRC(NUM_SRC), .PRIV_LAST(PRIV_LAST)) u_pick (
      .src_in    (src_in),
      .gen_en    (gen_en),
      .mask_row  (mask_q[c]),
      .route_col (rcol),
      .hit       (irq_out[c]),
      .id        (ack_id[c])
    );
  end

  logic [31:0] rd_d;

  always_comb begin
    rd_d = '0;
    if (bus_addr == A_INFO) begin
      rd_d[ID_W+1:2] = ID_W'(NUM_SRC);
    end else if (bus_addr == A_ACK) begin
      rd_d[ID_W-1:0] = cpu_ok ? ack_id[bus_cpu] : NONE_ID;
    end else if (rt_hit) begin
      rd_d[NUM_CPU-1:0] = route_q[rt_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync)   bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_d;
  end
endmodule

// File: rtl/irq_two_gate_ctrl_chk.sv
module irq_two_gate_ctrl_chk
  import icm_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int NUM_SRC = 64,
  localparam int IDX_W = $clog2(NUM_SRC),
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic                             clk,
  input logic                             rst_sync,
  input logic [NUM_SRC-1:0]               src_in,
  input logic [CPU_W-1:0]                 bus_cpu,
  input logic                             bus_wr,
  input logic                             bus_rd,
  input logic [11:0]                      bus_addr,
  input logic [31:0]                      bus_wdata,
  input logic [31:0]                      bus_rdata,
  input logic [NUM_CPU-1:0]               irq_out,
  input logic [NUM_SRC-1:0]               gen_en,
  input logic [NUM_CPU-1:0][NUM_SRC-1:0]  mask_q
);
  // R3
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (bus_wr && bus_addr == A_EN_SET && bus_wdata < NUM_SRC)
    |=> gen_en[$past(bus_wdata[IDX_W-1:0])]);

  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (bus_wr && bus_addr == A_EN_CLR && bus_wdata < NUM_SRC)
    |=> !gen_en[$past(bus_wdata[IDX_W-1:0])]);

  // R4
  msk_set_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (bus_wr && bus_addr == A_MSK_SET && bus_wdata < NUM_SRC && 32'(bus_cpu) < NUM_CPU)
    |=> mask_q[$past(bus_cpu)][$past(bus_wdata[IDX_W-1:0])]);

  // R6
  irq_needs_enabled_src_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (|irq_out) |-> (|(src_in & gen_en)));

  // R8
  ack_range_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (bus_rd && bus_addr == A_ACK)
    |=> (bus_rdata[ID_W-1:0] == NONE_ID || 32'(bus_rdata[ID_W-1:0]) < NUM_SRC));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    !bus_rd |=> $stable(bus_rdata));

  // R10
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    !(bus_rd && bus_wr));
endmodule

bind irq_two_gate_ctrl irq_two_gate_ctrl_chk #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst_sync  (rst_sync),
  .src_in    (src_in),
  .bus_cpu   (bus_cpu),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .gen_en    (gen_en),
  .mask_q    (mask_q)
);

// File: tb/test_irq_two_gate_ctrl.sv
`timescale 1ns/1ps
module test_irq_two_gate_ctrl;
  localparam int NC = 4;
  localparam int NS = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src_in;
  logic [1:0]    bus_cpu;
  logic          bus_wr, bus_rd;
  logic [11:0]   bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] irq_out;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_two_gate_ctrl i_irq_two_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_cpu(bus_cpu),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // behavioural reference model
  bit       m_en [NS];
  bit       m_msk[NC][NS];
  bit [3:0] m_rt [NS];
  logic [31:0] exp_rd;

  function automatic int pend_id(int c);
    for (int s = 0; s < NS; s++)
      if (src_in[s] && m_en[s] && !m_msk[c][s] && (s <= 28 || m_rt[s][c])) return s;
    return 1023;
  endfunction

  function automatic logic [31:0] model_read(int c, logic [11:0] a);
    if (a == 12'h000) return 32'(NS) << 2;
    if (a == 12'h800) return 32'(pend_id(c));
    if (a >= 12'h400 && a < 12'h400 + 12'(4*NS) && a[1:0] == 2'b00) return 32'(m_rt[(a - 12'h400) >> 2]);
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) begin
        m_en[s] = 0; m_rt[s] = 0;
        for (int c = 0; c < NC; c++) m_msk[c][s] = 1;
      end
      exp_rd = 0;
    end else begin
      if (bus_rd) exp_rd = model_read(int'(bus_cpu), bus_addr);
      if (bus_wr) begin
        int v;
        v = (bus_wdata < 32'(NS)) ? int'(bus_wdata) : -1;
        case (bus_addr)
          12'h010: if (v >= 0) m_en[v] = 1;
          12'h014: if (v >= 0) m_en[v] = 0;
          12'h808: if (v >= 0) m_msk[bus_cpu][v] = 1;
          12'h80C: if (v >= 0) m_msk[bus_cpu][v] = 0;
          default: if (bus_addr >= 12'h400 && bus_addr < 12'h400 + 12'(4*NS) && bus_addr[1:0] == 2'b00)
                     m_rt[(bus_addr - 12'h400) >> 2] = bus_wdata[3:0];
        endcase
      end
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  initial forever begin
    @(posedge clk); #15;
    if (started) begin
      logic [NC-1:0] ei;
      for (int c = 0; c < NC; c++) ei[c] = (pend_id(c) != 1023);
      chk(irq_out == ei, "R9 irq_out", irq_out, ei);
      chk(bus_rdata == exp_rd, "R10 rdata", bus_rdata, exp_rd);
    end
  end

  task automatic wr(int c, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_cpu = 2'(c); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
    #5;
  endtask

  task automatic rd(int c, logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_cpu = 2'(c); bus_addr = a; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    #5;
    chk(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; src_in = '0; bus_cpu = 0; bus_wr = 0; bus_rd = 0;
    bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    started = 1;

    // R1 reset state
    chk(irq_out == 0, "R1 irq_out", irq_out, 0);
    for (int c = 0; c < NC; c++) rd(c, 12'h800, 1023, "R1 ack");
    rd(0, 12'h000, 32'(NS) << 2, "R2 info");

    // R5 routing words
    wr(0, 12'h400 + 4*40, 32'h4);
    rd(1, 12'h400 + 4*40, 4, "R5 route");
    wr(0, 12'h400 + 4*41, 32'hFFFF_FFF3);
    rd(0, 12'h400 + 4*41, 3, "R5 upper");

    // shared source 40 routed to CPU2
    src_in[40] = 1;
    wr(0, 12'h010, 40);
    chk(irq_out == 0, "R6 masked", irq_out, 0);
    wr(2, 12'h80C, 40);
    chk(irq_out == 4'b0100, "R6 routed", irq_out, 4);
    rd(2, 12'h800, 40, "R8 ack");
    rd(2, 12'h800, 40, "R8 not cleared");
    wr(1, 12'h80C, 40);
    chk(irq_out == 4'b0100, "R6 not routed", irq_out, 4);

    // private source 5
    src_in[5] = 1;
    wr(0, 12'h010, 5);
    wr(1, 12'h80C, 5);
    chk(irq_out == 4'b0110, "R7 private", irq_out, 6);
    rd(1, 12'h800, 5, "R7 ack");
    rd(0, 12'h800, 1023, "R4 other cpu");
    wr(2, 12'h80C, 5);
    rd(2, 12'h800, 5, "R8 lowest wins");
    wr(3, 12'h014, 5);
    rd(2, 12'h800, 40, "R3 clear");
    chk(irq_out == 4'b0100, "R3 irq", irq_out, 4);

    // out-of-range index ignored
    wr(0, 12'h014, 40 + 64);
    rd(2, 12'h800, 40, "R3 out of range");
    wr(0, 12'h014, 32'h400 | 40);
    rd(2, 12'h800, 40, "R3 high bits");
    wr(2, 12'h808, 40);
    chk(irq_out == 0, "R4 mask", irq_out, 0);

    // boundary 28 / 29
    src_in[28] = 1; src_in[29] = 1;
    wr(0, 12'h010, 28); wr(0, 12'h010, 29);
    wr(3, 12'h80C, 28); wr(3, 12'h80C, 29);
    rd(3, 12'h800, 28, "R7 src28");
    @(negedge clk); src_in[28] = 0;
    rd(3, 12'h800, 1023, "R6 src29 unrouted");
    chk(irq_out[3] == 0, "R6 irq3", irq_out[3], 0);
    wr(0, 12'h400 + 4*29, 32'h8);
    rd(3, 12'h800, 29, "R6 src29 routed");

    // read data holding and unmapped
    repeat (3) @(negedge clk);
    chk(bus_rdata == 29, "R10 hold", bus_rdata, 29);
    rd(0, 12'h7F0, 0, "R10 unmapped");
    rd(0, 12'h010, 0, "R10 write-only");

    // random phase, compared each cycle against the model
    for (int i = 0; i < 1500; i++) begin
      int op, c, n;
      op = $urandom_range(0, 9);
      c  = $urandom_range(0, 3);
      n  = $urandom_range(0, 79);
      if ($urandom_range(0, 2) == 0) begin
        @(negedge clk); src_in[$urandom_range(0, NS-1)] ^= 1'b1;
      end
      case (op)
        0: wr(c, 12'h010, n);
        1: wr(c, 12'h014, n);
        2: wr(c, 12'h808, n);
        3: wr(c, 12'h80C, n);
        4: wr(c, 12'h400 + 12'(4*(n % NS)), $urandom);
        5: wr(c, 12'h010, 32'h400 | n);
        6: rd(c, 12'h000, 32'(NS) << 2, "R2 info");
        7: rd(c, 12'h400 + 12'(4*(n % NS)), 32'(m_rt[n % NS]), "R5 route");
        default: begin
          @(negedge clk);
          bus_cpu = 2'(c); bus_addr = 12'h800; bus_rd = 1;
          @(negedge clk); bus_rd = 0;
        end
      endcase
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule